// File: doc/BRIEF.md
# Level-Triggered Interrupt Request Gateway

This block is the per-source front end of a platform interrupt controller. Each of up to 31 sources, numbered 1 to 31, drives a level-sensitive request line. The gateway turns a high line into one pending request and then locks that source out until software reports that it has finished servicing the source.

The arbitration logic downstream reads the pending-bit vector. A claim strobe that carries a source ID takes the request away from the pending set. A completion strobe that carries the same ID ends the lockout. If the line is still high when completion arrives, a new request forms on the following clock.

Each source has two flags: a pending bit and an in-service flag. A request is forwarded only when both flags are clear. Forwarding sets both flags. A claim clears the pending bit, and a completion clears the in-service flag. As a result, no source ever has more than one outstanding request. ID 0 names no source, so strobes that carry ID 0 do nothing.

Top module: `irq_gateway`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, every pending bit is 0 and every in-service flag is clear, whatever the source lines are doing.
- R2: A source whose line is high and whose pending bit and in-service flag are both clear has its pending bit set at the next rising clock edge.
- R3: A claim (valid strobe, ID = n, with n in 1 to 31) for a pending source n clears pending bit n at the next edge. Other sources are not affected.
- R4: Once source n's request has been latched, its pending bit does not rise again before a completion with ID n is received. This holds after a claim even if the line stays high.
- R5: A claim or completion that carries ID 0 changes no pending bit and no lockout.
- R6: A completion for a source that is not in service has no effect.
- R7: When a completion for source n is sampled at one edge and line n is still high, pending bit n is set at the following edge, provided the bit was cleared earlier by a claim.
- R8: A pending bit stays set until a claim for its ID. A completion that arrives while the bit is still pending ends the lockout but leaves the bit set, and no second request is formed.
- R9: A low line forwards nothing. A line that falls after its request was latched does not clear the pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl_i | input | NSRC (bits NSRC:1) | Level request line of each source; bit n is source n |
| claim_vld_i | input | 1 | Claim strobe, one cycle per claim |
| claim_id_i | input | IDW | Source ID being claimed |
| done_vld_i | input | 1 | Completion strobe, one cycle per completion |
| done_id_i | input | IDW | Source ID whose service has finished |
| pend_o | output | NSRC (bits NSRC:1) | Pending bit of each source |

## Verification
The bench targets four cases:
- A claim made while the line is held high. A gateway with no lockout would re-raise pending at once.
- A completion that arrives before the claim. A design that did not hold the pending bit would drop it, or would queue a duplicate request.
- Strobes that carry ID 0. A decoder that aliased ID 0 onto a real source would clear or unlock that source.
- The one-edge delay between a completion and the fresh request. An off-by-one here shows up as pending rising on the wrong cycle.

Random lines, claims and completions are compared every cycle against a bench model of the pending and in-service flags.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

    // State held for one interrupt source
    typedef struct packed {
        logic pend;   // request waiting for a claim
        logic svc;    // request issued, completion not yet seen
    } gw_state_t;

    localparam gw_state_t GW_IDLE = '{pend: 1'b0, svc: 1'b0};

endpackage

// File: rtl/irq_gw_idsel.sv
// Turns a strobe plus a source ID into a one-hot hit vector over sources 1..NSRC.
// ID 0 and IDs above NSRC match no source.
module irq_gw_idsel #(
    parameter int NSRC = 31,
    parameter int IDW  = 5
) (
    input  logic            vld_i,
    input  logic [IDW-1:0]  id_i,
    output logic [NSRC:1]   hit_o
);

    for (genvar n = 1; n <= NSRC; n++) begin : g_hit
        assign hit_o[n] = vld_i && (id_i == IDW'(n));
    end

endmodule

// File: rtl/irq_gw_cell.sv
// Gateway state for one source: pending bit and in-service lockout.
module irq_gw_cell
    import irq_gw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic claim_hit_i,
    input  logic done_hit_i,
    output logic pend_o,
    output logic svc_o
);

    gw_state_t st_d, st_q;
    logic      fwd;

    always_comb begin
        st_d = st_q;
        // A new request goes out only when nothing is pending or in service
        fwd  = line_i && !st_q.pend && !st_q.svc;

        if (done_hit_i) begin
            st_d.svc = 1'b0;
        end
        if (claim_hit_i) begin
            st_d.pend = 1'b0;
        end
        if (fwd) begin
            st_d.pend = 1'b1;
            st_d.svc  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GW_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign svc_o  = st_q.svc;

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway #(
    parameter  int NSRC = 31,
    localparam int IDW  = $clog2(NSRC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC:1]   src_lvl_i,
    input  logic            claim_vld_i,
    input  logic [IDW-1:0]  claim_id_i,
    input  logic            done_vld_i,
    input  logic [IDW-1:0]  done_id_i,
    output logic [NSRC:1]   pend_o
);

    logic [NSRC:1] claim_hit;
    logic [NSRC:1] done_hit;
    logic [NSRC:1] svc_q;

    irq_gw_idsel #(.NSRC(NSRC), .IDW(IDW)) u_claim_sel (
        .vld_i (claim_vld_i),
        .id_i  (claim_id_i),
        .hit_o (claim_hit)
    );

    irq_gw_idsel #(.NSRC(NSRC), .IDW(IDW)) u_done_sel (
        .vld_i (done_vld_i),
        .id_i  (done_id_i),
        .hit_o (done_hit)
    );

    for (genvar n = 1; n <= NSRC; n++) begin : g_src
        irq_gw_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .line_i      (src_lvl_i[n]),
            .claim_hit_i (claim_hit[n]),
            .done_hit_i  (done_hit[n]),
            .pend_o      (pend_o[n]),
            .svc_o       (svc_q[n])
        );
    end

endmodule

// File: rtl/irq_gw_chk.sv
module irq_gw_chk #(
    parameter int NSRC = 31,
    parameter int IDW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC:1]   src_lvl_i,
    input logic            claim_vld_i,
    input logic [IDW-1:0]  claim_id_i,
    input logic            done_vld_i,
    input logic [IDW-1:0]  done_id_i,
    input logic [NSRC:1]   pend_o,
    input logic [NSRC:1]   svc_q
);

    for (genvar n = 1; n <= NSRC; n++) begin : g_chk
        // R2 / R9: pending only rises after its line was high
        assert_rise_needs_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_o[n]) |-> $past(src_lvl_i[n]));

        // R3: a claim of a pending source clears it
        assert_claim_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_vld_i && claim_id_i == IDW'(n) && pend_o[n]) |=> !pend_o[n]);

        // R4: a request can only form while the source is out of service
        assert_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_o[n]) |-> !$past(svc_q[n]));

        // R5 / R6: the lockout only ends on a completion naming this source
        assert_unlock_by_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(svc_q[n]) |-> $past(done_vld_i && done_id_i == IDW'(n)));

        // R8: pending holds until a claim for its own ID
        assert_pend_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[n] && !(claim_vld_i && claim_id_i == IDW'(n))) |=> pend_o[n]);
    end

endmodule

bind irq_gateway irq_gw_chk #(.NSRC(NSRC), .IDW(IDW)) u_gw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_lvl_i   (src_lvl_i),
    .claim_vld_i (claim_vld_i),
    .claim_id_i  (claim_id_i),
    .done_vld_i  (done_vld_i),
    .done_id_i   (done_id_i),
    .pend_o      (pend_o),
    .svc_q       (svc_q)
);

// File: tb/irq_gateway_bench.sv
module irq_gateway_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 31;
    localparam int IDW  = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC:1]   src_lvl_i = '0;
    logic            claim_vld_i = 1'b0;
    logic [IDW-1:0]  claim_id_i = '0;
    logic            done_vld_i = 1'b0;
    logic [IDW-1:0]  done_id_i = '0;
    logic [NSRC:1]   pend_o;

    logic [NSRC:1]   m_pend = '0;
    logic [NSRC:1]   m_svc  = '0;
    int              n_chk = 0;
    int              n_fail = 0;
    bit              done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_gateway #(.NSRC(NSRC)) u_irq_gateway (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_lvl_i   (src_lvl_i),
        .claim_vld_i (claim_vld_i),
        .claim_id_i  (claim_id_i),
        .done_vld_i  (done_vld_i),
        .done_id_i   (done_id_i),
        .pend_o      (pend_o)
    );

    task automatic check(input string req, input logic [NSRC:1] act, input logic [NSRC:1] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pend actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model built from the requirements
    task automatic model_step();
        logic [NSRC:1] np = m_pend;
        logic [NSRC:1] ns = m_svc;
        for (int n = 1; n <= NSRC; n++) begin
            if (done_vld_i && done_id_i == IDW'(n)) ns[n] = 1'b0;
            if (claim_vld_i && claim_id_i == IDW'(n)) np[n] = 1'b0;
            if (src_lvl_i[n] && !m_pend[n] && !m_svc[n]) begin
                np[n] = 1'b1;
                ns[n] = 1'b1;
            end
        end
        m_pend = np;
        m_svc  = ns;
    endtask

    // Apply inputs (called just after a falling edge), clock once, compare at the next falling edge
    task automatic cyc(input string req, input logic [NSRC:1] lines,
                       input logic cv, input int cid, input logic dv, input int did);
        src_lvl_i   = lines;
        claim_vld_i = cv;
        claim_id_i  = IDW'(cid);
        done_vld_i  = dv;
        done_id_i   = IDW'(did);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(req, pend_o, m_pend);
    endtask

    localparam logic [NSRC:1] S5 = NSRC'(1) << 4;  // bit for source 5
    localparam logic [NSRC:1] S7 = NSRC'(1) << 6;  // bit for source 7

    initial begin
        void'($urandom(32'd5150));
        // R1: reset holds everything clear even with lines high
        src_lvl_i = '1;
        repeat (3) @(negedge clk);
        check("R1", pend_o, '0);
        src_lvl_i = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pend_o, '0);

        // R2: line up on an idle source
        cyc("R2", S5, 0, 0, 0, 0);
        check("R2", pend_o & S5, S5);
        // R9: line drops, pending stays
        cyc("R9", '0, 0, 0, 0, 0);
        check("R9", pend_o & S5, S5);
        // R3: claim clears only source 5; source 7 raised meanwhile
        cyc("R3", S5 | S7, 1, 5, 0, 0);
        check("R3", pend_o, S7);
        // R4: line held high after claim, no new request
        for (int k = 0; k < 4; k++) cyc("R4", S5, 0, 0, 0, 0);
        check("R4", pend_o & S5, '0);
        // R5: ID 0 claim and completion change nothing
        cyc("R5", S5, 1, 0, 1, 0);
        cyc("R5", S5, 0, 0, 0, 0);
        check("R5", pend_o, S7);
        // R7: completion with line high, request one edge later
        cyc("R7", S5, 0, 0, 1, 5);
        check("R7", pend_o & S5, '0);
        cyc("R7", S5, 0, 0, 0, 0);
        check("R7", pend_o & S5, S5);
        // R8: completion while still pending keeps the bit, no duplicate
        cyc("R8", S5, 0, 0, 1, 5);
        for (int k = 0; k < 3; k++) cyc("R8", S5, 0, 0, 0, 0);
        check("R8", pend_o & S5, S5);
        // R6: completion for a source no longer in service does nothing
        cyc("R6", S5, 0, 0, 1, 5);
        check("R6", pend_o & S5, S5);
        cyc("R6", '0, 0, 0, 1, 9);
        check("R6", pend_o, S5 | S7);
        // R8: now claim; unlocked already, so a fresh request forms one edge later
        cyc("R8", S5, 1, 5, 0, 0);
        check("R8", pend_o & S5, '0);
        cyc("R8", S5, 0, 0, 0, 0);
        check("R8", pend_o & S5, S5);

        // Random mix of lines, claims and completions (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int k = 0; k < 4000; k++) begin
            logic [NSRC:1] ln;
            ln = NSRC'($urandom) & NSRC'($urandom);
            cyc("R2_R3_R4_R8_random", ln, 1'($urandom), int'($urandom_range(0, NSRC)),
                1'($urandom), int'($urandom_range(0, NSRC)));
        end

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

endmodule